// File: doc/BRIEF.md
# Audio Codec Register Access Controller

This block sits on a processor's memory-mapped bus and lets software read or write one register inside an external audio codec. Software first loads the codec register number and, for a write, the 16-bit value. It then writes the control word with the start bit set and the direction bit chosen. The block passes the request to the link side, which runs the transfer over the serial codec link. When the transfer is over, the link side returns a one-cycle done strobe.

The start bit clears itself: it is never stored and always reads back as zero. The direction latched when the request starts decides which interrupt fires on completion. A codec write ends with a pulse on the request-done line. A codec read ends with a pulse on the reply-done line, and the returned 16-bit value is captured into the data register. A second start that arrives while a transfer is still open is dropped. Register slots that are not implemented read as zero and ignore writes.

Top module: `codec_reg_ctrl`

## Requirements
- R1: After reset every register reads zero, the link request is low and both interrupt lines are low.
- R2: Bit 0 of the control word (byte offset 0x0) is the start bit and bit 1 is the direction (1 = write to codec, 0 = read from codec). A control write keeps bits 31..1 as written, and bit 0 always reads back 0.
- R3: A start written while idle raises link_req at the next clock edge. link_req stays high until link_done. While it is high, link_dir shows the direction, link_addr shows the codec address register (offset 0x4) and link_wdata shows the data register (offset 0x8).
- R4: link_done during a write-direction transfer gives exactly one clock cycle of irq_req_done, registered (high in the cycle after link_done). irq_reply_done stays low.
- R5: link_done during a read-direction transfer gives exactly one clock cycle of irq_reply_done, registered (high in the cycle after link_done). irq_req_done stays low, and link_rdata is loaded into the data register.
- R6: A start written while a transfer is pending starts nothing: link_dir keeps its value and only one interrupt follows. The written control bits are still stored, with bit 0 cleared.
- R7: link_done while no transfer is pending has no effect: no interrupt fires and no register changes.
- R8: A register index with no register behind it (index 3 and above, byte offset = index times 4) reads zero, and a write to it changes no state.
- R9: The codec address register keeps only its low 7 bits and the data register only its low 16 bits. Their upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data for addr, combinational |
| link_req | output | 1 | Transfer pending toward the link side |
| link_dir | output | 1 | Latched direction, 1 = codec write |
| link_addr | output | CADDR_W | Codec register number |
| link_wdata | output | CDATA_W | Value to write to the codec |
| link_done | input | 1 | One-cycle completion strobe from the link |
| link_rdata | input | CDATA_W | Value read from the codec |
| irq_req_done | output | 1 | Pulse when a codec write completes |
| irq_reply_done | output | 1 | Pulse when a codec read completes |

## Verification
The bench builds the block with ADDR_W = 6 instead of the default 4. This widens the register index space to sixteen slots, so accesses to far unmapped indices such as 15 can be checked, along with index 3 that the default also has. The codec field widths stay at 7 and 16 bits, so writing all ones shows the truncation of R9 directly.

// File: rtl/codec_reg_ctrl.sv
module codec_reg_ctrl #(
  parameter int ADDR_W  = 4,
  parameter int CADDR_W = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               link_req,
  output logic               link_dir,
  output logic [CADDR_W-1:0] link_addr,
  output logic [CDATA_W-1:0] link_wdata,
  input  logic               link_done,
  input  logic [CDATA_W-1:0] link_rdata,
  output logic               irq_req_done,
  output logic               irq_reply_done
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CADDR = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CDATA = IDX_W'(2);

  logic [31:1]        ctrl_q;
  logic [CADDR_W-1:0] caddr_q;
  logic [CDATA_W-1:0] cdata_q;
  logic               pend_q, dir_q;

  wire [IDX_W-1:0] idx = addr[ADDR_W-1:2];
  wire wr_ctrl  = wr_en && (idx == IDX_CTRL);
  wire wr_caddr = wr_en && (idx == IDX_CADDR);
  wire wr_cdata = wr_en && (idx == IDX_CDATA);
  wire go       = wr_ctrl && wdata[0] && !pend_q;
  wire fin      = pend_q && link_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q         <= '0;
      caddr_q        <= '0;
      cdata_q        <= '0;
      pend_q         <= 1'b0;
      dir_q          <= 1'b0;
      irq_req_done   <= 1'b0;
      irq_reply_done <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wdata[31:1];
      if (wr_caddr) caddr_q <= wdata[CADDR_W-1:0];
      if (fin && !dir_q) cdata_q <= link_rdata;
      else if (wr_cdata) cdata_q <= wdata[CDATA_W-1:0];
      if (go) begin
        pend_q <= 1'b1;
        dir_q  <= wdata[1];
      end else if (fin) begin
        pend_q <= 1'b0;
      end
      irq_req_done   <= fin && dir_q;
      irq_reply_done <= fin && !dir_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_CTRL:  rdata = {ctrl_q, 1'b0};
      IDX_CADDR: rdata = {{(32-CADDR_W){1'b0}}, caddr_q};
      IDX_CDATA: rdata = {{(32-CDATA_W){1'b0}}, cdata_q};
      default:   rdata = '0;
    endcase
  end

  assign link_req   = pend_q;
  assign link_dir   = dir_q;
  assign link_addr  = caddr_q;
  assign link_wdata = cdata_q;

  a_r4_req_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_done |=> !irq_req_done);
  a_r5_reply_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    irq_reply_done |=> !irq_reply_done);
  a_r4_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req_done && irq_reply_done));
  a_r6_dir_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && !link_done) |=> (link_req && $stable(link_dir)));
  a_r7_req_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_done |-> $past(link_req && link_done && link_dir));
  a_r7_reply_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_reply_done |-> $past(link_req && link_done && !link_dir));
endmodule

// File: tb/tb_codec_reg_ctrl.sv
module tb_codec_reg_ctrl;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0, wr_en = 0, link_done = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic link_req, link_dir, irq_req_done, irq_reply_done;
  logic [6:0] link_addr;
  logic [15:0] link_wdata, link_rdata = '0;
  int checks = 0, fails = 0;

  codec_reg_ctrl #(.ADDR_W(AW), .CADDR_W(7), .CDATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .link_req(link_req), .link_dir(link_dir),
    .link_addr(link_addr), .link_wdata(link_wdata), .link_done(link_done),
    .link_rdata(link_rdata), .irq_req_done(irq_req_done),
    .irq_reply_done(irq_reply_done));

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(idx * 4); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int idx, output logic [31:0] d);
    @(negedge clk); addr = AW'(idx * 4); #1 d = rdata;
  endtask

  task automatic done_pulse(logic [15:0] rv);
    @(negedge clk); link_done = 1; link_rdata = rv;
    @(negedge clk); link_done = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin rd(i, v); check("R1 reg zero", v, 0); end
    check("R1 link_req", link_req, 0);
    check("R1 irqs", {irq_req_done, irq_reply_done}, 0);
  endtask

  task automatic t_go_readback;
    logic [31:0] v;
    wr(0, 32'hFFFF_FFF3);
    rd(0, v); check("R2 go reads 0", v, 32'hFFFF_FFF2);
    done_pulse(16'h0);
    @(negedge clk);
  endtask

  task automatic t_write_req;
    wr(1, 32'h55); wr(2, 32'hBEEF); wr(0, 32'h3);
    check("R3 link_req", link_req, 1);
    check("R3 link_dir", link_dir, 1);
    check("R3 link_addr", link_addr, 32'h55);
    check("R3 link_wdata", link_wdata, 32'hBEEF);
    done_pulse(16'h0);
    check("R4 irq_req_done", irq_req_done, 1);
    check("R4 reply quiet", irq_reply_done, 0);
    @(negedge clk);
    check("R4 pulse one cycle", irq_req_done, 0);
    check("R3 req dropped", link_req, 0);
  endtask

  task automatic t_read_req;
    logic [31:0] v;
    wr(0, 32'h1);
    check("R3 read link_dir", link_dir, 0);
    done_pulse(16'h1234);
    check("R5 irq_reply_done", irq_reply_done, 1);
    check("R5 req quiet", irq_req_done, 0);
    @(negedge clk);
    check("R5 pulse one cycle", irq_reply_done, 0);
    rd(2, v); check("R5 captured data", v, 32'h1234);
  endtask

  task automatic t_busy_go;
    logic [31:0] v;
    int n = 0;
    wr(0, 32'h1);
    wr(0, 32'h3);
    check("R6 dir held", link_dir, 0);
    rd(0, v); check("R6 ctrl stored", v, 32'h2);
    done_pulse(16'h0042);
    n = n + int'(irq_reply_done) + int'(irq_req_done);
    check("R6 reply irq", irq_reply_done, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); n = n + int'(irq_reply_done) + int'(irq_req_done);
    end
    check("R6 single irq", n, 1);
    check("R6 nothing queued", link_req, 0);
  endtask

  task automatic t_stray_done;
    logic [31:0] v;
    done_pulse(16'hAAAA);
    check("R7 no irq", {irq_req_done, irq_reply_done}, 0);
    @(negedge clk);
    check("R7 no irq later", {irq_req_done, irq_reply_done}, 0);
    rd(2, v); check("R7 data kept", v, 32'h0042);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(3, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
    rd(3, v); check("R8 idx3 zero", v, 0);
    rd(15, v); check("R8 idx15 zero", v, 0);
    rd(0, v); check("R8 ctrl kept", v, 32'h2);
    rd(1, v); check("R8 caddr kept", v, 32'h55);
    rd(2, v); check("R8 cdata kept", v, 32'h0042);
    check("R8 no start", link_req, 0);
  endtask

  task automatic t_widths;
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    rd(1, v); check("R9 caddr 7 bits", v, 32'h7F);
    rd(2, v); check("R9 cdata 16 bits", v, 32'hFFFF);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_go_readback();
    t_write_req();
    t_read_req();
    t_busy_go();
    t_stray_done();
    t_unmapped();
    t_widths();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule